// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block lets software reach PHY registers over a two-wire management bus. Software writes one packed command word into a small 32-bit register window. The block then sends a Clause 22 frame on an MDC clock line and an MDIO data line. The MDC clock is divided down from the system clock.

A write frame completes on its own, with nothing to read back. A read frame releases the data line for the turnaround and the sixteen data bits. The value the PHY returns is placed in a data register, together with a two-bit error code. A one-deep command slot lets software queue the next command while the current frame is still being shifted out. Two status bits tell software whether a command is waiting in the slot and whether the serial engine is active.

The pad stays outside the block. The block drives a separate output, an output enable and an input, so a tristate buffer can be placed next to the pin.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the status word (byte offset 0x0) and the read-data word (byte offset 0xC) both read as zero, and `mdio_oe` is low.
- R2: A write to the command word (byte offset 0x8) whose bit 31 is clear is ignored. The pending bit stays clear and no frame appears on the bus.
- R3: Command bits 29:25 give the PHY address, bits 24:20 the register address and bits 19:4 the write data. Bit 2 set selects a read; otherwise bit 1 selects a write. The frame is sent MSB first: 32 ones, start `01`, opcode (`10` read, `01` write), PHY address, register address. A write frame continues with turnaround `10` and the 16 data bits.
- R4: Status bit 2 (pending) is set from the accepted command write until the engine takes the command. Status bit 3 (busy) is set from that take until the frame's last bit has completed.
- R5: While a command is pending, any further command write is dropped. While busy with pending clear, a new command is queued and runs right after the current frame.
- R6: `mdio_oe` is high for all 64 bits of a write frame and for only the first 46 bits of a read frame. It is low while idle.
- R7: After a read, bits 15:0 of the read-data word hold the 16 bits the PHY drove, first bit as MSB. Bits 17:16 are `00` when the PHY drove the line low in the second turnaround bit.
- R8: If the line is high in the second turnaround bit of a read, bits 17:16 read `11`. Bits 17:16 are cleared when each new read starts.
- R9: MDC has a period of 2×`HALF_DIV` system clocks. `mdio_o` changes only just after MDC falls, and `mdio_i` is sampled on MDC rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven toward the pad |
| mdio_oe | output | 1 | Output enable for the pad |
| mdio_i | input | 1 | Data value seen at the pad |

## Verification
A small PHY model captures every frame bit on MDC rising edges and answers reads. The vector walk mixes reads and writes with all-ones, all-zeros and alternating addresses and data, so a swapped field, a wrong opcode or an off-by-one shift shows up as a bit mismatch. Reads are run both with a PHY that responds and with a silent line. This separates good data from the error code and shows whether the error code is cleared when the next read starts. Directed cases queue a command behind a running frame and then send a third command that must be dropped. Counting the frames afterwards separates correct one-deep queueing from overwriting or double execution.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_VALID_BIT = 31;
  localparam int CMD_PHY_LSB   = 25;
  localparam int CMD_REG_LSB   = 20;
  localparam int CMD_DATA_LSB  = 4;
  localparam int CMD_RD_BIT    = 2;
  localparam int ST_PEND_BIT   = 2;
  localparam int ST_BUSY_BIT   = 3;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = (cnt == TOP);
  assign rise_tick = tick & ~mdc;
  assign fall_tick = tick & mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_MDC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(mdc)); // R9
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        req_valid,
  input  mdio_cmd_t   req,
  output logic        take,
  output logic        busy,
  output logic        done_rd,
  output logic [17:0] rd_word,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int CW        = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] LAST   = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] TA_IDX = CW'(PRE_LEN + 14);
  localparam logic [CW-1:0] TA2    = CW'(PRE_LEN + 15);

  logic [FRAME_LEN-1:0] sh;
  logic [FRAME_LEN-1:0] frame;
  logic [CW-1:0]        cnt;
  logic [CW-1:0]        cnt_nx;
  logic                 is_rd;
  logic                 ta_err;
  logic [15:0]          rx;

  assign take    = req_valid & ~busy & fall_tick;
  assign cnt_nx  = cnt + 1'b1;
  assign rd_word = {ta_err ? 2'b11 : 2'b00, rx};
  assign frame   = {{PRE_LEN{1'b1}}, 2'b01, req.rd ? 2'b10 : 2'b01,
                    req.phy, req.regad, 2'b10,
                    req.rd ? 16'hFFFF : req.wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      is_rd   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      ta_err  <= 1'b0;
      rx      <= '0;
      done_rd <= 1'b0;
    end else begin
      done_rd <= 1'b0;
      if (fall_tick) begin
        if (!busy) begin
          if (req_valid) begin
            busy    <= 1'b1;
            cnt     <= '0;
            sh      <= frame;
            is_rd   <= req.rd;
            mdio_o  <= frame[FRAME_LEN-1];
            mdio_oe <= 1'b1;
            ta_err  <= 1'b0;
          end
        end else if (cnt == LAST) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
          done_rd <= is_rd;
        end else begin
          cnt     <= cnt_nx;
          sh      <= {sh[FRAME_LEN-2:0], 1'b0};
          mdio_o  <= sh[FRAME_LEN-2];
          mdio_oe <= !(is_rd && (cnt_nx >= TA_IDX));
        end
      end
      if (rise_tick && busy && is_rd) begin
        if (cnt == TA2) ta_err <= mdio_i;
        if (cnt > TA2)  rx <= {rx[14:0], mdio_i};
      end
    end
  end

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe); // R6
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && cnt >= TA_IDX) |-> !mdio_oe); // R6
  AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
    take |=> busy); // R4
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $past(fall_tick)); // R9
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 50,
  parameter int ADDR_W   = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] OFF_STATUS = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFF_CMD    = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] OFF_DATA   = ADDR_W'(4'hC);

  logic        rise_tick, fall_tick;
  logic        pend, take, busy, done_rd;
  logic [17:0] rd_word;
  logic [17:0] data_q;
  mdio_cmd_t   qcmd;
  logic        cmd_hit;
  logic        unused_bits;

  assign cmd_hit     = reg_we && (reg_addr == OFF_CMD);
  assign unused_bits = ^{reg_wdata[30], reg_wdata[3], reg_wdata[1:0]};

  mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(rst), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .req_valid(pend), .req(qcmd), .take(take), .busy(busy),
    .done_rd(done_rd), .rd_word(rd_word),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      qcmd <= '0;
    end else if (take) begin
      pend <= 1'b0;
    end else if (cmd_hit && reg_wdata[CMD_VALID_BIT] && !pend) begin
      pend       <= 1'b1;
      qcmd.rd    <= reg_wdata[CMD_RD_BIT];
      qcmd.phy   <= reg_wdata[CMD_PHY_LSB +: 5];
      qcmd.regad <= reg_wdata[CMD_REG_LSB +: 5];
      qcmd.wdata <= reg_wdata[CMD_DATA_LSB +: 16];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 data_q <= '0;
    else if (take && qcmd.rd) data_q <= '0;
    else if (done_rd)        data_q <= rd_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        OFF_STATUS: begin
          reg_rdata[ST_PEND_BIT] <= pend;
          reg_rdata[ST_BUSY_BIT] <= busy;
        end
        OFF_DATA: reg_rdata[17:0] <= data_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && !reg_wdata[CMD_VALID_BIT] && !pend) |=> !pend); // R2
  AST_PEND_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> busy); // R4
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (pend && cmd_hit && !take) |=> (pend && $stable(qcmd))); // R5
  AST_RD_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (take && qcmd.rd) |=> (data_q[17:16] == 2'b00)); // R8
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.HALF_DIV(HALF), .ADDR_W(4), .PRE_LEN(32)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model
  logic        phy_drv = 1'b0, phy_val = 1'b1, phy_ack = 1'b1;
  logic [15:0] phy_data = '0;
  logic        in_frame = 1'b0;
  logic [63:0] cap = '0;
  int          rise_n = 0, oe_n = 0, frames = 0;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  always @(posedge mdc) begin
    if (!in_frame && mdio_oe) begin
      in_frame = 1'b1; rise_n = 1; cap = {63'b0, mdio_i}; oe_n = 1;
    end else if (in_frame) begin
      cap = {cap[62:0], mdio_i};
      oe_n = oe_n + (mdio_oe ? 1 : 0);
      rise_n = rise_n + 1;
      if (rise_n == 64) begin in_frame = 1'b0; frames = frames + 1; end
    end
  end

  always @(negedge mdc) begin
    if (in_frame && !mdio_oe && phy_ack && rise_n >= 47 && rise_n < 64) begin
      phy_drv = 1'b1;
      phy_val = (rise_n == 47) ? 1'b0 : phy_data[15-(rise_n-48)];
    end else begin
      phy_drv = 1'b0;
      phy_val = 1'b1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_we = 1'b0;
    @(posedge clk); #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(4'h0, s);
      if (s[3:2] == 2'b00) break;
    end
  endtask

  function automatic logic [31:0] mk_cmd(input logic r, input logic [4:0] p,
                                         input logic [4:0] g, input logic [15:0] d);
    return {1'b1, 1'b0, p, g, d, 1'b0, r, ~r, 1'b0};
  endfunction

  function automatic logic [63:0] mk_frame(input logic r, input logic [4:0] p,
                                           input logic [4:0] g, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, r ? 2'b10 : 2'b01, p, g, 2'b10, d};
  endfunction

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
    logic [15:0] resp;
    logic        ack;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 5'h1F, 5'h00, 16'hA5C3, 16'h0000, 1'b1},
    '{1'b1, 5'h15, 5'h0A, 16'h0000, 16'h1234, 1'b1},
    '{1'b0, 5'h00, 5'h1F, 16'h0000, 16'h0000, 1'b1},
    '{1'b1, 5'h0A, 5'h15, 16'h0000, 16'hFFFF, 1'b1},
    '{1'b1, 5'h03, 5'h02, 16'h0000, 16'h8001, 1'b0},
    '{1'b1, 5'h1F, 5'h1F, 16'h0000, 16'h0000, 1'b1}
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int f0;
    realtime t0, t1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd(4'h0, v); check("R1 status", 64'(v), 64'h0);
    rd(4'hC, v); check("R1 data", 64'(v), 64'h0);
    check("R1 oe", 64'(mdio_oe), 64'h0);

    // R9 MDC period
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    check("R9 mdc period ns", 64'(int'(t1 - t0)), 64'(2 * HALF * 4));

    // vector walk: R3 R6 R7 R8
    foreach (VEC[i]) begin
      phy_data = VEC[i].resp; phy_ack = VEC[i].ack;
      wait_idle();
      wr(4'h8, mk_cmd(VEC[i].rd, VEC[i].phy, VEC[i].regad, VEC[i].wdata));
      wait_idle();
      if (VEC[i].rd) begin
        check("R3 read header", 64'(cap[63:18]),
              64'(mk_frame(1'b1, VEC[i].phy, VEC[i].regad, 16'h0) >> 18));
        check("R6 read oe bits", 64'(oe_n), 64'd46);
        rd(4'hC, v);
        if (VEC[i].ack) check("R7 read data", 64'(v), {46'b0, 2'b00, VEC[i].resp});
        else            check("R8 no-ack code", 64'(v), {46'b0, 2'b11, 16'hFFFF});
      end else begin
        check("R3 write frame", cap, mk_frame(1'b0, VEC[i].phy, VEC[i].regad, VEC[i].wdata));
        check("R6 write oe bits", 64'(oe_n), 64'd64);
      end
    end

    // R8: error code cleared when a new read starts
    phy_ack = 1'b0;
    wr(4'h8, mk_cmd(1'b1, 5'h2, 5'h3, 16'h0));
    wait_idle();
    rd(4'hC, v); check("R8 error set", 64'(v[17:16]), 64'h3);
    phy_ack = 1'b1; phy_data = 16'h5A5A;
    wr(4'h8, mk_cmd(1'b1, 5'h2, 5'h3, 16'h0));
    for (int i = 0; i < 200; i++) begin
      rd(4'h0, v);
      if (v[3]) break;
    end
    rd(4'hC, v); check("R8 error cleared at start", 64'(v[17:16]), 64'h0);
    wait_idle();

    // R2: invalid command ignored
    f0 = frames;
    wr(4'h8, mk_cmd(1'b1, 5'h4, 5'h5, 16'h0) & 32'h7FFF_FFFF);
    rd(4'h0, v); check("R2 no pending", 64'(v), 64'h0);
    repeat (300) @(posedge clk);
    check("R2 no frame", 64'(frames - f0), 64'h0);

    // R4 R5: queue behind a running frame, third command dropped
    f0 = frames;
    wr(4'h8, mk_cmd(1'b0, 5'h01, 5'h02, 16'h1111));
    for (int i = 0; i < 200; i++) begin
      rd(4'h0, v);
      if (v[3:2] == 2'b10) break;
    end
    wr(4'h8, mk_cmd(1'b0, 5'h06, 5'h07, 16'hBEEF));
    rd(4'h0, v); check("R4 pending and busy", 64'(v[3:2]), 64'h3);
    wr(4'h8, mk_cmd(1'b0, 5'h09, 5'h0B, 16'hDEAD));
    wait_idle();
    check("R5 frame count", 64'(frames - f0), 64'd2);
    check("R5 queued frame kept", cap, mk_frame(1'b0, 5'h06, 5'h07, 16'hBEEF));
    check("R6 idle oe", 64'(mdio_oe), 64'h0);

    finish_run();
  end
endmodule